// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block is a first-level data cache between a processor port and a 64-bit memory bus. It holds two ways, and each way is indexed like a small direct-mapped array. Every processor access is looked up in both ways one cycle after it is accepted. Read hits return from the arrays. A read miss allocates a line in one way, chosen by a single recency bit per set. The whole 32-byte line is then fetched as a four-beat burst. If the chosen line holds dirty data, it is first written out as a four-beat burst.

The write policy belongs to each line, not to the whole cache. When a line is filled, the controller records the value of the not-write-through input (`nwt`) at that moment. Lines filled with `nwt` = 1 absorb write hits and become dirty. Lines filled with `nwt` = 0 update their cached copy and also send each write to memory, and the write finishes only when memory acknowledges it. Write misses never allocate. When the cache-disable input (`cache_dis`) is set, accesses skip the arrays and go to memory as single beats.

The processor issues one request at a time by pulsing `cpu_req` while the controller is idle. It then waits for the one-cycle `cpu_ready` pulse. Memory holds each beat until `mem_ack`.

Top module: `dcache2w`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low, and every line is invalid.
- R2: A read miss with the cache enabled issues exactly four burst reads (`mem_burst`=1, `mem_we`=0). The beat addresses run upward in 8-byte steps from the 32-byte-aligned line base, and the processor receives the requested 64-bit word.
- R3: A read hit returns the stored word with no memory bus cycle.
- R4: A line filled while `nwt`=1 is a write-back line. A write hit to it merges the enabled bytes into the cache, marks the line dirty and produces no bus cycle, whatever `nwt` is at the time of the write.
- R5: A line filled while `nwt`=0 is a write-through line. A write hit to it updates the cached word and issues one single write (`mem_burst`=0) carrying the processor's byte enables. `cpu_ready` follows the memory acknowledge, even if `nwt` is 1 at the time of the write.
- R6: A write miss issues one single write and does not allocate, so a later read of that address misses.
- R7: On a read miss the victim is an invalid way if one exists (way 0 first). Otherwise it is the way of the set that was not touched most recently.
- R8: A dirty victim is written back as four burst writes to its own line addresses before the first fill beat.
- R9: With `cache_dis`=1 (sampled when the request is accepted), reads and writes are single-beat bus cycles, and the arrays are neither looked up nor allocated.
- R10: Byte address layout is 3 bits for the byte in a word, 2 bits for the word in a line, `IDX_W` set bits, and the tag above them. Requests are 8-byte aligned, and a bus request holds its address and controls steady until acknowledged.
- R11: Every accepted request produces exactly one `cpu_ready` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_dis | input | 1 | 1 = bypass the arrays for this request |
| nwt | input | 1 | Policy recorded into a line at fill: 1 write-back, 0 write-through |
| cpu_req | input | 1 | Request pulse, accepted while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address, 8-byte aligned |
| cpu_wdata | input | 64 | Write data |
| cpu_be | input | 8 | Byte enables for writes |
| cpu_rdata | output | 64 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bus beat request |
| mem_we | output | 1 | 1 = bus write |
| mem_burst | output | 1 | 1 = beat belongs to a four-beat line transfer |
| mem_addr | output | ADDR_W | Beat byte address, 8-byte aligned |
| mem_wdata | output | 64 | Bus write data |
| mem_be | output | 8 | Bus byte enables |
| mem_rdata | input | 64 | Bus read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted or completed |

## Verification
On every cycle, the assertions check four things: that `cpu_ready` is a single-cycle pulse; that bus beats hold steady until acknowledged; that a write hit to a write-back line completes without touching the bus; and that a dirty write-back leads straight into the fill. They also confirm that bypassed requests never burst and that write-through completions wait for the acknowledge. Other properties depend on history across accesses, and only the bench scenarios can show them. These are the correctness of returned data against a byte-merged reference memory, the policy a line keeps after `nwt` changes, and the victim choice from recency. They also include the absence of allocation after a write miss or a bypassed access, and the contents memory holds after a write-back.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int NWAYS = 2;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_SINGLE
  } dc_state_e;
endpackage

// File: rtl/dc_data_ram.sv
module dc_data_ram #(
  parameter int AW     = 9,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [AW-1:0]       waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [AW-1:0]       raddr,
  output logic [DATA_W-1:0]   rdata
);
  localparam int NB = DATA_W / 8;
  logic [DATA_W-1:0] store [2**AW];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (we && be[b]) store[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
    rdata <= store[raddr];
  end
endmodule

// File: rtl/dc_tag_ram.sv
module dc_tag_ram #(
  parameter int AW = 7,
  parameter int W  = 22
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [2**AW];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/dcache2w.sv
module dcache2w
  import dc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int OFS_W  = 5,
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cache_dis,
  input  logic                nwt,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_burst,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ack
);
  localparam int BE_W   = DATA_W / 8;
  localparam int WSEL_W = $clog2(BE_W);
  localparam int BEAT_W = OFS_W - WSEL_W;
  localparam int SETS   = 2 ** IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int TE_W   = TAG_W + 2;          // {dirty, wb, tag}
  localparam int DA_W   = IDX_W + BEAT_W;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(2 ** BEAT_W - 1);

  dc_state_e state;
  logic [ADDR_W-1:WSEL_W] req_a;
  logic                   req_we, req_dis, req_nwt;
  logic [DATA_W-1:0]      req_wdata, rdata_q;
  logic [BE_W-1:0]        req_be;
  logic [BEAT_W-1:0]      cnt;
  logic                   victim_q, ready_q;
  logic [SETS-1:0]        lru_q;
  logic [SETS-1:0]        valid_q [NWAYS];

  wire [IDX_W-1:0]  req_idx  = req_a[OFS_W +: IDX_W];
  wire [TAG_W-1:0]  req_tag  = req_a[ADDR_W-1 -: TAG_W];
  wire [BEAT_W-1:0] req_beat = req_a[WSEL_W +: BEAT_W];
  wire [IDX_W-1:0]  cpu_idx  = cpu_addr[OFS_W +: IDX_W];

  logic [TE_W-1:0]   tag_rd [NWAYS];
  logic [DATA_W-1:0] dat_rd [NWAYS];
  logic [NWAYS-1:0]  hit, tag_we, dat_we;
  logic [TE_W-1:0]   tag_wd;
  logic [DA_W-1:0]   dat_waddr, dat_raddr;
  logic [DATA_W-1:0] dat_wd;
  logic [BE_W-1:0]   dat_wbe;
  logic [IDX_W-1:0]  tag_raddr;
  logic              hit_any, hit_w, vict, vict_dirty, fill_last;

  generate
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
      dc_tag_ram #(.AW(IDX_W), .W(TE_W)) u_tag (
        .clk(clk), .we(tag_we[w]), .waddr(req_idx), .wdata(tag_wd),
        .raddr(tag_raddr), .rdata(tag_rd[w]));
      dc_data_ram #(.AW(DA_W), .DATA_W(DATA_W)) u_dat (
        .clk(clk), .we(dat_we[w]), .be(dat_wbe), .waddr(dat_waddr),
        .wdata(dat_wd), .raddr(dat_raddr), .rdata(dat_rd[w]));
      assign hit[w] = valid_q[w][req_idx] && (tag_rd[w][TAG_W-1:0] == req_tag);
    end
  endgenerate

  assign hit_any    = |hit;
  assign hit_w      = hit[1];
  assign vict       = !valid_q[0][req_idx] ? 1'b0 :
                      !valid_q[1][req_idx] ? 1'b1 : lru_q[req_idx];
  assign vict_dirty = valid_q[vict][req_idx] && tag_rd[vict][TAG_W+1];
  assign fill_last  = (state == ST_FILL) && mem_ack && (cnt == LAST);

  // Array read addresses: sync read, so present next cycle's need now
  always_comb begin
    tag_raddr = (state == ST_IDLE) ? cpu_idx : req_idx;
    case (state)
      ST_IDLE:   dat_raddr = {cpu_idx, cpu_addr[WSEL_W +: BEAT_W]};
      ST_LOOKUP: dat_raddr = {req_idx, {BEAT_W{1'b0}}};
      ST_WBACK:  dat_raddr = {req_idx, mem_ack ? cnt + 1'b1 : cnt};
      default:   dat_raddr = {req_idx, cnt};
    endcase
  end

  // Array writes: store-hit merge, fill beats, tag updates
  always_comb begin
    tag_we    = '0;
    dat_we    = '0;
    tag_wd    = {1'b1, 1'b1, req_tag};
    dat_waddr = {req_idx, req_beat};
    dat_wd    = req_wdata;
    dat_wbe   = req_be;
    if (state == ST_LOOKUP && !req_dis && hit_any && req_we) begin
      dat_we[hit_w] = 1'b1;
      tag_we[hit_w] = tag_rd[hit_w][TAG_W];       // write-back line turns dirty
    end else if (state == ST_FILL && mem_ack) begin
      dat_we[victim_q] = 1'b1;
      dat_waddr        = {req_idx, cnt};
      dat_wd           = mem_rdata;
      dat_wbe          = '1;
      tag_we[victim_q] = fill_last;
      tag_wd           = {1'b0, req_nwt, req_tag};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ready_q    <= 1'b0;
      cnt        <= '0;
      victim_q   <= 1'b0;
      lru_q      <= '0;
      for (int w = 0; w < NWAYS; w++) valid_q[w] <= '0;
    end else begin
      ready_q <= 1'b0;
      case (state)
        ST_IDLE: if (cpu_req) begin
          req_a     <= cpu_addr[ADDR_W-1:WSEL_W];
          req_we    <= cpu_we;
          req_wdata <= cpu_wdata;
          req_be    <= cpu_be;
          req_dis   <= cache_dis;
          req_nwt   <= nwt;
          cnt       <= '0;
          state     <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (req_dis) state <= ST_SINGLE;
          else if (hit_any) begin
            lru_q[req_idx] <= ~hit_w;
            if (!req_we) begin
              rdata_q <= dat_rd[hit_w];
              ready_q <= 1'b1;
              state   <= ST_IDLE;
            end else if (tag_rd[hit_w][TAG_W]) begin
              ready_q <= 1'b1;
              state   <= ST_IDLE;
            end else state <= ST_SINGLE;
          end else if (req_we) state <= ST_SINGLE;
          else begin
            victim_q <= vict;
            state    <= vict_dirty ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (cnt == req_beat) rdata_q <= mem_rdata;
          if (cnt == LAST) begin
            valid_q[victim_q][req_idx] <= 1'b1;
            lru_q[req_idx]             <= ~victim_q;
            ready_q                    <= 1'b1;
            state                      <= ST_IDLE;
          end
        end
        ST_SINGLE: if (mem_ack) begin
          if (!req_we) rdata_q <= mem_rdata;
          ready_q <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL) || (state == ST_SINGLE);
  assign mem_we    = (state == ST_WBACK) || (state == ST_SINGLE && req_we);
  assign mem_burst = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_wdata = (state == ST_WBACK) ? dat_rd[victim_q] : req_wdata;
  assign mem_be    = (state == ST_SINGLE && req_we) ? req_be : '1;

  always_comb begin
    case (state)
      ST_WBACK: mem_addr = {tag_rd[victim_q][TAG_W-1:0], req_idx, cnt, {WSEL_W{1'b0}}};
      ST_FILL:  mem_addr = {req_tag, req_idx, cnt, {WSEL_W{1'b0}}};
      default:  mem_addr = {req_a, {WSEL_W{1'b0}}};
    endcase
  end

  // R11: completion is a single-cycle pulse
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R10: a pending beat keeps address and controls until acknowledged
  assert_hold_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_burst)));
  // R10: processor requests are word aligned
  assert_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_req |-> (cpu_addr[WSEL_W-1:0] == '0));
  // R4: write hit on a write-back line finishes without the bus
  assert_wb_hit_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOKUP && !req_dis && req_we && hit_any && tag_rd[hit_w][TAG_W])
      |=> (cpu_ready && !mem_req));
  // R8: last write-back beat is followed by a fill read
  assert_wb_then_fill_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WBACK && mem_ack && cnt == LAST) |=> (mem_burst && !mem_we));
  // R9: bypassed requests never burst
  assert_bypass_single_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && req_dis) |-> !mem_burst);
  // R5: a single-beat cycle cannot complete before its acknowledge
  assert_wt_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SINGLE && !mem_ack) |=> !cpu_ready);
endmodule

// File: tb/tb_dcache2w.sv
module tb_dcache2w;
  localparam int AW = 16;
  localparam int NW = 2 ** (AW - 3);

  logic        clk = 1'b0, rst = 1'b1;
  logic        cache_dis = 1'b0, nwt = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [63:0] cpu_wdata = '0;
  logic [7:0]  cpu_be = '0;
  logic [63:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we, mem_burst;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  dcache2w #(.ADDR_W(AW), .IDX_W(2)) dut (
    .clk(clk), .rst(rst), .cache_dis(cache_dis), .nwt(nwt),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [63:0] mem_m [NW];
  logic [63:0] ref_m [NW];
  logic [1:0]  tr_kind [16];
  logic [AW-1:0] tr_addr [16];
  int tr_n = 0;

  function automatic logic [63:0] merge(logic [63:0] o, logic [63:0] n, logic [7:0] be);
    for (int b = 0; b < 8; b++) if (be[b]) o[b*8 +: 8] = n[b*8 +: 8];
    return o;
  endfunction

  function automatic logic [AW-1:0] A(int tag, int set, int beat);
    return AW'(tag * 128 + set * 32 + beat * 8);
  endfunction

  // Memory model: ack every other cycle, trace each acknowledged beat
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack   = 1'b1;
      mem_rdata = mem_m[mem_addr[AW-1:3]];
      if (mem_we) mem_m[mem_addr[AW-1:3]] = merge(mem_m[mem_addr[AW-1:3]], mem_wdata, mem_be);
      if (tr_n < 16) begin
        tr_kind[tr_n] = {mem_we, mem_burst};
        tr_addr[tr_n] = mem_addr;
      end
      tr_n++;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [63:0] wd,
                        input logic [7:0] be, output logic [63:0] rd);
    tr_n = 0;
    cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; cpu_req = 1'b1;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_ready) @(negedge clk);
    rd = cpu_rdata;
    if (we) ref_m[a[AW-1:3]] = merge(ref_m[a[AW-1:3]], wd, be);
    @(negedge clk);
    chk(!cpu_ready, "R11 ready pulse width", 64'(cpu_ready), 64'd0);
  endtask

  // kinds: 00 single read, 01 burst read, 10 single write, 11 burst write
  task automatic chk_trace(input string r, input int n, input logic [1:0] k0,
                           input logic [AW-1:0] b0, input logic [1:0] k1, input logic [AW-1:0] b1);
    chk(tr_n == n, {r, " beat count"}, 64'(tr_n), 64'(n));
    if (tr_n == n) begin
      for (int i = 0; i < n; i++) begin
        logic [1:0] ek;
        logic [AW-1:0] ea;
        if (n == 8 && i >= 4) begin ek = k1; ea = b1 + AW'((i - 4) * 8); end
        else begin ek = k0; ea = b0 + (k0[0] ? AW'(i * 8) : '0); end
        chk(tr_kind[i] == ek && tr_addr[i] == ea, {r, " beat kind/address"},
            {46'd0, tr_kind[i], tr_addr[i]}, {46'd0, ek, ea});
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(i_unused()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int i_unused();
    return done ? 1 : 0;
  endfunction

  initial begin
    logic [63:0] rd;
    for (int i = 0; i < NW; i++) begin
      mem_m[i] = {32'(i) * 32'h9E3779B1, 32'(i) ^ 32'h5A5A0000};
      ref_m[i] = mem_m[i];
    end
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !mem_req, "R1 reset outputs", {62'd0, cpu_ready, mem_req}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R7 R10: fill both ways of every set (invalid ways first)
    for (int s = 0; s < 4; s++) for (int t = 0; t < 2; t++) begin
      access(1'b0, A(t, s, s), 64'd0, 8'd0, rd);
      chk(rd == ref_m[A(t, s, s) >> 3], "R2 fill data", rd, ref_m[A(t, s, s) >> 3]);
      chk_trace("R2 R10 fill burst", 4, 2'b01, A(t, s, 0), 2'b01, '0);
    end
    // R3: every word of every resident line hits quietly
    for (int s = 0; s < 4; s++) for (int t = 0; t < 2; t++) for (int b = 0; b < 4; b++) begin
      access(1'b0, A(t, s, b), 64'd0, 8'd0, rd);
      chk(rd == ref_m[A(t, s, b) >> 3] && tr_n == 0, "R3 read hit", rd, ref_m[A(t, s, b) >> 3]);
    end
    // R4: write-back line stays write-back after nwt drops
    nwt = 1'b0;
    access(1'b1, A(0, 0, 1), 64'h1111_2222_3333_4444, 8'h0F, rd);
    chk(tr_n == 0, "R4 write hit no bus", 64'(tr_n), 64'd0);
    access(1'b0, A(0, 0, 1), 64'd0, 8'd0, rd);
    chk(rd == ref_m[A(0, 0, 1) >> 3] && tr_n == 0, "R4 merged data", rd, ref_m[A(0, 0, 1) >> 3]);
    chk(mem_m[A(0, 0, 1) >> 3] != ref_m[A(0, 0, 1) >> 3], "R4 memory stale while dirty",
        mem_m[A(0, 0, 1) >> 3], ref_m[A(0, 0, 1) >> 3]);
    // R7: recency picks the victim in set 2
    access(1'b0, A(0, 2, 0), 64'd0, 8'd0, rd);
    access(1'b0, A(2, 2, 0), 64'd0, 8'd0, rd);
    chk_trace("R7 miss fill", 4, 2'b01, A(2, 2, 0), 2'b01, '0);
    access(1'b0, A(0, 2, 3), 64'd0, 8'd0, rd);
    chk(tr_n == 0, "R7 recent way kept", 64'(tr_n), 64'd0);
    access(1'b0, A(1, 2, 3), 64'd0, 8'd0, rd);
    chk(tr_n == 4, "R7 older way evicted", 64'(tr_n), 64'd4);
    // R5: write-through line (filled with nwt=0) written with nwt=1
    access(1'b0, A(1, 1, 0), 64'd0, 8'd0, rd);
    access(1'b0, A(2, 1, 0), 64'd0, 8'd0, rd);
    chk_trace("R5 wt fill", 4, 2'b01, A(2, 1, 0), 2'b01, '0);
    nwt = 1'b1;
    access(1'b1, A(2, 1, 2), 64'hAAAA_BBBB_CCCC_DDDD, 8'hF0, rd);
    chk_trace("R5 write-through", 1, 2'b10, A(2, 1, 2), 2'b10, '0);
    chk(mem_m[A(2, 1, 2) >> 3] == ref_m[A(2, 1, 2) >> 3], "R5 memory updated",
        mem_m[A(2, 1, 2) >> 3], ref_m[A(2, 1, 2) >> 3]);
    access(1'b0, A(2, 1, 2), 64'd0, 8'd0, rd);
    chk(rd == ref_m[A(2, 1, 2) >> 3] && tr_n == 0, "R5 cache updated", rd, ref_m[A(2, 1, 2) >> 3]);
    // R6: write miss goes out once and does not allocate
    access(1'b1, A(5, 3, 2), 64'h0123_4567_89AB_CDEF, 8'hFF, rd);
    chk_trace("R6 write miss", 1, 2'b10, A(5, 3, 2), 2'b10, '0);
    access(1'b0, A(5, 3, 2), 64'd0, 8'd0, rd);
    chk(rd == ref_m[A(5, 3, 2) >> 3], "R6 data after miss", rd, ref_m[A(5, 3, 2) >> 3]);
    chk_trace("R6 no allocation", 4, 2'b01, A(5, 3, 0), 2'b01, '0);
    // R8: dirty victim is written back before the fill
    access(1'b0, A(1, 0, 0), 64'd0, 8'd0, rd);
    access(1'b0, A(3, 0, 2), 64'd0, 8'd0, rd);
    chk(rd == ref_m[A(3, 0, 2) >> 3], "R8 fill data", rd, ref_m[A(3, 0, 2) >> 3]);
    chk_trace("R8 write-back then fill", 8, 2'b11, A(0, 0, 0), 2'b01, A(3, 0, 0));
    chk(mem_m[A(0, 0, 1) >> 3] == ref_m[A(0, 0, 1) >> 3], "R8 memory after write-back",
        mem_m[A(0, 0, 1) >> 3], ref_m[A(0, 0, 1) >> 3]);
    // R9: cache disabled
    cache_dis = 1'b1;
    access(1'b0, A(0, 2, 3), 64'd0, 8'd0, rd);
    chk(rd == ref_m[A(0, 2, 3) >> 3], "R9 bypass read data", rd, ref_m[A(0, 2, 3) >> 3]);
    chk_trace("R9 bypass read", 1, 2'b00, A(0, 2, 3), 2'b00, '0);
    access(1'b1, A(6, 1, 3), 64'hFEED_FACE_DEAD_BEEF, 8'h3C, rd);
    chk_trace("R9 bypass write", 1, 2'b10, A(6, 1, 3), 2'b10, '0);
    cache_dis = 1'b0;
    access(1'b0, A(6, 1, 3), 64'd0, 8'd0, rd);
    chk(rd == ref_m[A(6, 1, 3) >> 3], "R9 data after bypass", rd, ref_m[A(6, 1, 3) >> 3]);
    chk_trace("R9 bypass did not allocate", 4, 2'b01, A(6, 1, 0), 2'b01, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule